// File: doc/BRIEF.md
# Serial Byte Shift Engine for a Two-Wire Bus

This block is the byte-wide shift path of a two-wire serial bus controller. Software writes a byte into it, and that byte leaves on the data line one bit at a time, most significant bit first. Each bit moves out in step with the serial clock. The same register also collects incoming bits. Each bit is taken from the data line on a rising edge of the serial clock and enters at the least significant end, while the older bits move one place toward the top.

The serial clock arrives asynchronously. It passes through a short chain of synchronising flops in the internal clock domain before the engine acts on it, so a received bit lands two internal cycles after the clock line first reads high.

Software writes are accepted only while the interface is enabled. An accepted write does three things:
- It clears the bit counter.
- It arms the engine for one byte.
- In master mode, it sends a one-cycle request to the separate serial-clock generator.

Reads of the register are never gated. A byte-complete pulse marks the eighth captured bit. After that pulse the engine stays idle until software writes again.

Top module: `i2cShiftByte`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the read port shows 8'hFF, the data output is 1 (released), the bit counter is 0, and byte-complete and the clock request are both 0.
- R2: A write that is accepted (write strobe high with interface enable high) loads the written byte into the register at that clock edge and clears the bit counter to 0.
- R3: A write strobe that arrives while interface enable is 0 leaves the register, the bit counter and the clock request unchanged.
- R4: The clock request is high for exactly the one cycle that follows an accepted write made with master mode 1. It stays low after a write made with master mode 0.
- R5: The read port always shows the present register contents, whatever the value of interface enable.
- R6: While the engine is armed, a serial clock rise causes a capture. If the clock input is first sampled high at clock edge k (after being low at edge k-1), the register shifts left at edge k+2 and takes the data input sampled at edge k+2 into bit 0.
- R7: The data output is updated to register bit 7 only at clock edges where the synchronised clock level is low, that is, where the clock input was low two edges earlier. At every other edge it holds its value.
- R8: Each capture adds 1 to the bit counter. The eighth capture wraps the counter to 0 and raises byte-complete for one cycle. After that, clock rises cause no shift and no count until the next accepted write.
- R9: When an accepted write and a capture fall on the same clock edge, the write wins: the register takes the written byte and the counter becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Software write strobe |
| wrData | input | 8 | Byte to load |
| rdData | output | 8 | Present register contents |
| ifEnable | input | 1 | Interface enable; gates writes |
| masterMode | input | 1 | Master mode; writes then request clocking |
| sclIn | input | 1 | Serial clock line as sampled (asynchronous) |
| sdaIn | input | 1 | Serial data line as sampled |
| sdaOut | output | 1 | Serial data drive value |
| bitCount | output | 3 | Bits captured in the current byte |
| byteDone | output | 1 | One-cycle pulse after the eighth capture |
| startClk | output | 1 | One-cycle request to the serial clock generator |

## Verification
Several properties are checked on every cycle:
- A gated write leaves the register alone.
- An accepted write loads the byte and clears the counter.
- The clock request pulses only after master-mode writes.
- Every capture is a one-place left shift.
- Byte-complete rises only when the counter wraps from seven.
- The data output moves only while the synchronised clock is low.

Other behaviour can only be shown by the bench scenarios, where a cycle-level reference model tracks the clock history:
- the exact two-cycle capture latency;
- the value assembled from eight received bits;
- the idle hold after a completed byte;
- write-over-capture priority on the same edge;
- the bit order seen on the data output during a transmit.

// File: rtl/i2cShiftPkg.sv
package i2cShiftPkg;
  typedef struct packed {
    logic load;
    logic shift;
    logic sdaUpd;
  } shStrobe_t;
endpackage

// File: rtl/i2cShiftCtl.sv
module i2cShiftCtl
  import i2cShiftPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             ifEnable,
  input  logic             masterMode,
  input  logic             sclIn,
  output shStrobe_t        stb,
  output logic             sclLvl,
  output logic [CNT_W-1:0] bitCount,
  output logic             byteDone,
  output logic             startClk
);
  logic [SYNC_STAGES:0] syncQ;
  logic sclPrev, sclRise, accept, armed;

  // synchroniser stages plus one extra stage for edge detection
  for (genvar g = 0; g <= SYNC_STAGES; g++) begin : gSync
    if (g == 0) begin : gFirst
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ[g] <= 1'b0;
        else       syncQ[g] <= sclIn;
    end else begin : gRest
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ[g] <= 1'b0;
        else       syncQ[g] <= syncQ[g-1];
    end
  end

  assign sclLvl  = syncQ[SYNC_STAGES-1];
  assign sclPrev = syncQ[SYNC_STAGES];
  assign sclRise = sclLvl & ~sclPrev;
  assign accept  = wrEn & ifEnable;

  always_comb begin
    stb.load   = accept;
    stb.shift  = sclRise & armed & ~accept;
    stb.sdaUpd = ~sclLvl;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCount <= '0;
      armed    <= 1'b0;
      byteDone <= 1'b0;
      startClk <= 1'b0;
    end else begin
      byteDone <= 1'b0;
      startClk <= accept & masterMode;
      if (accept) begin
        bitCount <= '0;
        armed    <= 1'b1;
      end else if (stb.shift) begin
        if (bitCount == CNT_W'(DATA_W - 1)) begin
          bitCount <= '0;
          armed    <= 1'b0;
          byteDone <= 1'b1;
        end else begin
          bitCount <= bitCount + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/i2cShiftData.sv
module i2cShiftData
  import i2cShiftPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  shStrobe_t         stb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              sdaIn,
  output logic [DATA_W-1:0] rdData,
  output logic              sdaOut
);
  logic [DATA_W-1:0] shReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg  <= '1;
      sdaOut <= 1'b1;
    end else begin
      if (stb.load)       shReg <= wrData;
      else if (stb.shift) shReg <= {shReg[DATA_W-2:0], sdaIn};
      if (stb.sdaUpd)     sdaOut <= shReg[DATA_W-1];
    end
  end

  assign rdData = shReg;
endmodule

// File: rtl/i2cShiftByte.sv
module i2cShiftByte
  import i2cShiftPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              ifEnable,
  input  logic              masterMode,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaOut,
  output logic [CNT_W-1:0]  bitCount,
  output logic              byteDone,
  output logic              startClk
);
  shStrobe_t stb;
  logic sclLvl;

  i2cShiftCtl #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) uCtl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .ifEnable(ifEnable),
    .masterMode(masterMode), .sclIn(sclIn), .stb(stb), .sclLvl(sclLvl),
    .bitCount(bitCount), .byteDone(byteDone), .startClk(startClk)
  );

  i2cShiftData #(.DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData), .sdaIn(sdaIn),
    .rdData(rdData), .sdaOut(sdaOut)
  );
endmodule

// File: rtl/i2cShiftByteChk.sv
module i2cShiftByteChk #(
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] rdData,
  input logic              ifEnable,
  input logic              masterMode,
  input logic              sdaOut,
  input logic [CNT_W-1:0]  bitCount,
  input logic              byteDone,
  input logic              startClk,
  input logic              shiftStb,
  input logic              sclLvl
);
  assert_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && ifEnable) |=> (rdData == $past(wrData) && bitCount == '0));

  assert_gated_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !ifEnable && !shiftStb) |=> $stable(rdData));

  assert_start_req_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && ifEnable && masterMode) |=> startClk);

  assert_start_only_R4: assert property (@(posedge clk) disable iff (!rstN)
    startClk |-> $past(wrEn && ifEnable && masterMode));

  assert_shift_left_R6: assert property (@(posedge clk) disable iff (!rstN)
    shiftStb |=> (rdData[DATA_W-1:1] == $past(rdData[DATA_W-2:0])));

  assert_sda_low_R7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOut) |-> $past(!sclLvl));

  assert_wrap_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(byteDone) |-> ($past(bitCount) == CNT_W'(DATA_W - 1) && bitCount == '0));
endmodule

bind i2cShiftByte i2cShiftByteChk #(.DATA_W(DATA_W)) uChk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
  .ifEnable(ifEnable), .masterMode(masterMode), .sdaOut(sdaOut),
  .bitCount(bitCount), .byteDone(byteDone), .startClk(startClk),
  .shiftStb(stb.shift), .sclLvl(sclLvl)
);

// File: tb/tb_i2cShiftByte.sv
`timescale 1ns/1ps
module tb_i2cShiftByte;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic ifEnable = 1'b0;
  logic masterMode = 1'b0;
  logic sclIn = 1'b0;
  logic sdaIn = 1'b1;
  logic sdaOut;
  logic [2:0] bitCount;
  logic byteDone;
  logic startClk;

  always #2 clk = ~clk;  // 250 MHz

  i2cShiftByte dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .ifEnable(ifEnable), .masterMode(masterMode), .sclIn(sclIn), .sdaIn(sdaIn),
    .sdaOut(sdaOut), .bitCount(bitCount), .byteDone(byteDone), .startClk(startClk)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit running = 0;
  bit sawDone = 0;

  // behavioural reference model
  int mReg, mCnt, mSda;
  bit mArmed, mDone, mStart;
  int sclHist[$];

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mReg = 8'hFF; mCnt = 0; mSda = 1; mArmed = 0; mDone = 0; mStart = 0;
      sclHist = '{0, 0, 0};
    end else begin
      bit rise, lowLvl, acc;
      rise   = (sclHist[1] == 1) && (sclHist[2] == 0);
      lowLvl = (sclHist[1] == 0);
      if (lowLvl) mSda = (mReg >> 7) & 1;
      acc    = wrEn && ifEnable;
      mStart = acc && masterMode;
      mDone  = 0;
      if (acc) begin
        mReg = wrData; mCnt = 0; mArmed = 1;
      end else if (rise && mArmed) begin
        mReg = ((mReg << 1) | sdaIn) & 8'hFF;
        if (mCnt == 7) begin
          mCnt = 0; mArmed = 0; mDone = 1;
        end else mCnt++;
      end
      sclHist.push_front(sclIn);
      void'(sclHist.pop_back());
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (running) begin
      check("R6 rdData", rdData, mReg);
      check("R7 sdaOut", sdaOut, mSda);
      check("R8 bitCount", bitCount, mCnt);
      check("R8 byteDone", byteDone, mDone);
      check("R4 startClk", startClk, mStart);
      if (byteDone) sawDone = 1;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic doWrite(input logic [7:0] d);
    wrEn = 1'b1; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic sclBit(input logic b);
    sdaIn = b; sclIn = 1'b0;
    repeat (4) @(negedge clk);
    sclIn = 1'b1;
    repeat (4) @(negedge clk);
    sclIn = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 rdData", rdData, 8'hFF);
    check("R1 sdaOut", sdaOut, 1);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 bitCount", bitCount, 0);
    check("R1 byteDone", byteDone, 0);
    check("R1 startClk", startClk, 0);
    running = 1;

    // R3: gated write
    ifEnable = 1'b0; masterMode = 1'b1;
    doWrite(8'h3C);
    check("R3 gated write", rdData, 8'hFF);
    check("R3 no request", startClk, 0);

    // R2/R4: accepted master write
    ifEnable = 1'b1;
    doWrite(8'hA5);
    check("R2 load", rdData, 8'hA5);
    check("R2 counter clear", bitCount, 0);
    check("R4 request", startClk, 1);
    @(negedge clk);
    check("R4 request one cycle", startClk, 0);

    // R6/R8: receive 0x96
    for (int i = 7; i >= 0; i--) sclBit(8'h96 >> i & 1);
    repeat (4) @(negedge clk);
    check("R6 received byte", rdData, 8'h96);
    check("R8 byte complete seen", sawDone, 1);
    check("R8 counter wrapped", bitCount, 0);
    // R8: idle after byte
    sclBit(1'b0);
    repeat (4) @(negedge clk);
    check("R8 idle hold", rdData, 8'h96);

    // R5: read while disabled
    ifEnable = 1'b0;
    @(negedge clk);
    check("R5 read disabled", rdData, 8'h96);

    // R4/R7: slave-mode transmit, restarted mid-byte
    ifEnable = 1'b1; masterMode = 1'b0;
    doWrite(8'h5A);
    check("R4 no request in slave", startClk, 0);
    for (int i = 0; i < 3; i++) sclBit(1'b1);
    repeat (4) @(negedge clk);
    check("R8 partial count", bitCount, 3);
    doWrite(8'hC3);
    check("R2 restart clears count", bitCount, 0);
    for (int i = 0; i < 8; i++) sclBit(1'b1);
    repeat (4) @(negedge clk);
    check("R7 released after byte", sdaOut, 1);

    // R9: write on the capture edge
    doWrite(8'h11);
    sclIn = 1'b0; repeat (4) @(negedge clk);
    sclIn = 1'b1; sdaIn = 1'b1;
    repeat (2) @(negedge clk);
    doWrite(8'hE7);
    check("R9 write wins data", rdData, 8'hE7);
    check("R9 write wins count", bitCount, 0);
    repeat (4) @(negedge clk);
    sclIn = 1'b0;
    repeat (6) @(negedge clk);

    running = 0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule